// File: doc/BRIEF.md
# Multi-slot inter-processor mailbox

This block gives two processors a shared set of message slots for exchanging fixed-size messages. Each slot has a control word and a message buffer. The control word holds a one-hot lifecycle state and an acknowledge-style bit. The message buffer is eight 32-bit words. Both processors reach every slot over a single 32-bit memory-mapped bus with a registered read path. A slot occupies a 64-byte window, so the slot index is the address above bit 6.

A sender claims a slot by writing the transmit state and fills the message words. The peer reads the words and then writes the acknowledged state. If the slot's acknowledge style is automatic, that write sends the slot straight back to idle, and a sender polling for idle sees the message complete. If the style is interrupt-based, the slot stays in the acknowledged state. In that case the block drives a one-cycle event on the slot's bit of `ack_evt` toward an interrupt collector that lies outside this block.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every slot's control word reads 0x10 (state idle, acknowledge style 0), every message word reads 0, and `ack_evt` is all zero.
- R2: Read data appears on `bus_rdata` in the cycle after the read request. It holds that value until the next read, even across writes.
- R3: Word offsets 0x04 to 0x20 of slot m (byte address 0x40*m + offset) hold message words 0 to 7. Each word is written and read back independently.
- R4: The control word is at offset 0x00. Bits [7:4] hold the state, with the codes idle=0x1, transmit=0x2, receive=0x4 and acknowledged=0x8. Bit 0 holds the acknowledge style (1 = automatic, 0 = by event). All other bits read as 0, and writing them has no effect.
- R5: A control write whose bits [7:4] are not one-hot leaves the stored state unchanged, but bit 0 is still written.
- R6: A control write with state acknowledged and bit 0 = 1 leaves the slot idle (the control word reads 0x11) and raises no event.
- R7: A control write with state acknowledged and bit 0 = 0 stores the acknowledged state. It also makes `ack_evt` equal to the one-hot bit for that slot for exactly one cycle, the cycle after the write.
- R8: A slot in the acknowledged state with event-style acknowledge stays acknowledged until software writes a new state.
- R9: Offsets 0x24 to 0x3C and addresses that are not word-aligned read as 0. Writes to them change nothing.
- R10: An access to one slot never changes the control word or message words of another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address: slot in [10:6], offset in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ack_evt | output | 32 | One-cycle acknowledge event per slot |

## Verification
Every write takes effect at the clock edge where it is presented. A read presented at edge N shows its data on `bus_rdata` just after edge N. An event caused by an acknowledge write presented at edge N is high only between edges N and N+1. The bench drives each access half a cycle before the edge and samples on the falling edge that follows it. So it checks read data and `ack_evt` in their due cycle, and it checks `ack_evt` once more one cycle later to confirm that the event has ended.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  localparam int WIN_LOG2 = 6;
  localparam logic [3:0] ST_IDLE = 4'b0001;
  localparam logic [3:0] ST_ACK  = 4'b1000;

  // next stored state for a control write; illegal (non one-hot) codes keep the old one
  function automatic logic [3:0] state_after(input logic [3:0] cur,
                                             input logic [3:0] req,
                                             input logic       auto_ack);
    if (!$onehot(req)) return cur;
    if (req == ST_ACK && auto_ack) return ST_IDLE;
    return req;
  endfunction

  function automatic logic ack_event(input logic [3:0] req, input logic auto_ack);
    return (req == ST_ACK) && !auto_ack;
  endfunction

  function automatic logic [31:0] mode_word(input logic [3:0] st, input logic auto_ack);
    return {24'd0, st, 3'd0, auto_ack};
  endfunction
endpackage

// File: rtl/ipc_mbx_decode.sv
module ipc_mbx_decode #(
  parameter int SLOTS     = 32,
  parameter int MSG_WORDS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = SLOT_W + ipc_mbx_pkg::WIN_LOG2,
  localparam int IDX_W  = $clog2(MSG_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output logic              is_mode,
  output logic              is_data,
  output logic [IDX_W-1:0]  word_idx
);
  logic [3:0] word;
  logic       aligned;

  assign slot     = addr[ADDR_W-1:ipc_mbx_pkg::WIN_LOG2];
  assign word     = addr[5:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign is_mode  = aligned && (word == 4'd0);
  assign is_data  = aligned && (word != 4'd0) && (int'(word) <= MSG_WORDS);
  assign word_idx = IDX_W'(word - 4'd1);
endmodule

// File: rtl/ipc_mbx_slot_bank.sv
module ipc_mbx_slot_bank #(
  parameter int SLOTS = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_mode,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [3:0]            wr_state,
  input  logic                  wr_auto,
  output logic [SLOTS-1:0][3:0] st_q,
  output logic [SLOTS-1:0]      auto_q,
  output logic [SLOTS-1:0]      evt_q
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    assign hit = wr_mode && (wr_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[i]   <= ipc_mbx_pkg::ST_IDLE;
        auto_q[i] <= 1'b0;
        evt_q[i]  <= 1'b0;
      end else begin
        evt_q[i] <= hit && ipc_mbx_pkg::ack_event(wr_state, wr_auto);
        if (hit) begin
          st_q[i]   <= ipc_mbx_pkg::state_after(st_q[i], wr_state, wr_auto);
          auto_q[i] <= wr_auto;
        end
      end
    end
  end
endmodule

// File: rtl/ipc_mbx_data_ram.sv
module ipc_mbx_data_ram #(
  parameter int SLOTS     = 32,
  parameter int MSG_WORDS = 8,
  parameter int DATA_W    = 32,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = $clog2(MSG_WORDS),
  localparam int DEPTH  = SLOTS * MSG_WORDS,
  localparam int MEM_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] loc;

  assign loc   = MEM_AW'(slot) * MEM_AW'(MSG_WORDS) + MEM_AW'(idx);
  assign rdata = mem[loc];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[loc] <= wdata;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int SLOTS     = 32,
  parameter int MSG_WORDS = 8,
  parameter int DATA_W    = 32,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = SLOT_W + ipc_mbx_pkg::WIN_LOG2,
  localparam int IDX_W  = $clog2(MSG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SLOTS-1:0]  ack_evt
);
  logic [SLOT_W-1:0]     slot;
  logic                  is_mode, is_data;
  logic [IDX_W-1:0]      word_idx;
  logic [SLOTS-1:0][3:0] slot_state;
  logic [SLOTS-1:0]      slot_auto;
  logic [DATA_W-1:0]     ram_rd;
  logic [DATA_W-1:0]     rd_next;
  logic                  wr_mode_ev, wr_data_ev, rd_ev;

  assign wr_mode_ev = bus_en && bus_we && is_mode;
  assign wr_data_ev = bus_en && bus_we && is_data;
  assign rd_ev      = bus_en && !bus_we;

  ipc_mbx_decode #(.SLOTS(SLOTS), .MSG_WORDS(MSG_WORDS)) u_dec (
    .addr(bus_addr), .slot(slot), .is_mode(is_mode),
    .is_data(is_data), .word_idx(word_idx)
  );

  ipc_mbx_slot_bank #(.SLOTS(SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode_ev), .wr_slot(slot),
    .wr_state(bus_wdata[7:4]), .wr_auto(bus_wdata[0]),
    .st_q(slot_state), .auto_q(slot_auto), .evt_q(ack_evt)
  );

  ipc_mbx_data_ram #(.SLOTS(SLOTS), .MSG_WORDS(MSG_WORDS), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_data_ev), .slot(slot),
    .idx(word_idx), .wdata(bus_wdata), .rdata(ram_rd)
  );

  always_comb begin
    if (is_mode)      rd_next = DATA_W'(ipc_mbx_pkg::mode_word(slot_state[slot], slot_auto[slot]));
    else if (is_data) rd_next = ram_rd;
    else              rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ev) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  localparam int SLOT_W = ADDR_W - 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [SLOTS-1:0]      ack_evt,
  input logic [SLOTS-1:0][3:0] slot_st
);
  logic ctl_wr, ack_irq_wr, ack_auto_wr;
  logic [SLOT_W-1:0] wslot;

  assign ctl_wr      = bus_en && bus_we && (bus_addr[5:0] == 6'd0);
  assign ack_irq_wr  = ctl_wr && (bus_wdata[7:4] == 4'h8) && !bus_wdata[0];
  assign ack_auto_wr = ctl_wr && (bus_wdata[7:4] == 4'h8) && bus_wdata[0];
  assign wslot       = bus_addr[ADDR_W-1:6];

  for (genvar i = 0; i < SLOTS; i++) begin : g_st
    a_r4_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(slot_st[i]));
  end

  a_r7_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_evt));

  a_r7_evt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt != '0) |-> $past(ack_irq_wr));

  a_r7_evt_fire: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq_wr |=> (ack_evt == (SLOTS'(1) << $past(wslot))));

  a_r6_auto_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_auto_wr |=> (slot_st[$past(wslot)] == 4'h1) && (ack_evt == '0));

  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_en && !bus_we) |-> $stable(bus_rdata));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ack_evt(ack_evt), .slot_st(slot_state)
);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ack_evt;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_evt(ack_evt));

  function automatic logic [10:0] adr(input int slot, input int off);
    return {5'(slot), 6'(off)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int slot, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = adr(slot, off); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int slot, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = adr(slot, off);
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 0, v);  check("R1 slot0 ctl", v, 32'h10);
    rd(17, 0, v); check("R1 slot17 ctl", v, 32'h10);
    rd(31, 0, v); check("R1 slot31 ctl", v, 32'h10);
    rd(5, 12, v); check("R1 data word", v, 32'h0);
    check("R1 ack_evt", ack_evt, 32'h0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    for (int w = 0; w < 8; w++) wr(2, 4 + 4*w, 32'hC0DE_0000 + 32'(w * 17));
    wr(3, 4, 32'h1234_5678);
    for (int w = 0; w < 8; w++) begin
      rd(2, 4 + 4*w, v);
      check("R3 data readback", v, 32'hC0DE_0000 + 32'(w * 17));
    end
    rd(3, 4, v); check("R3 slot3 word0", v, 32'h1234_5678);
    rd(3, 8, v); check("R10 slot3 word1 untouched", v, 32'h0);
    rd(2, 0, v); check("R10 slot2 ctl untouched", v, 32'h10);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    rd(3, 4, v); check("R2 read value", v, 32'h1234_5678);
    wr(3, 4, 32'hDEAD_BEEF);
    check("R2 rdata held over write", bus_rdata, 32'h1234_5678);
    rd(3, 4, v); check("R2 new read", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(4, 0, 32'h21); rd(4, 0, v); check("R4 tx auto", v, 32'h21);
    wr(4, 0, 32'hFFFF_FF4E); rd(4, 0, v); check("R4 rx, extra bits dropped", v, 32'h40);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    wr(4, 0, 32'h31); rd(4, 0, v); check("R5 two-hot state kept", v, 32'h41);
    wr(4, 0, 32'h00); rd(4, 0, v); check("R5 zero state kept", v, 32'h40);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    wr(6, 0, 32'h21);
    wr(6, 0, 32'h81);
    check("R6 no event", ack_evt, 32'h0);
    rd(6, 0, v); check("R6 back to idle", v, 32'h11);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(9, 0, 32'h20);
    wr(9, 0, 32'h80);
    check("R7 event pulse", ack_evt, 32'h1 << 9);
    @(negedge clk);
    check("R7 event one cycle", ack_evt, 32'h0);
    rd(9, 0, v); check("R7 state acked", v, 32'h80);
    repeat (20) @(negedge clk);
    rd(9, 0, v); check("R8 stays acked", v, 32'h80);
    wr(9, 0, 32'h10); rd(9, 0, v); check("R8 software idle", v, 32'h10);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(7, 32, 32'h0000_00A5);
    wr(7, 36, 32'hFFFF_FFFF);
    wr(7, 60, 32'hFFFF_FFFF);
    wr(7, 5, 32'hFFFF_FFFF);
    wr(7, 1, 32'hFFFF_FF81);
    rd(7, 36, v); check("R9 offset 0x24 reads 0", v, 32'h0);
    rd(7, 60, v); check("R9 offset 0x3C reads 0", v, 32'h0);
    rd(7, 33, v); check("R9 unaligned reads 0", v, 32'h0);
    rd(7, 32, v); check("R9 last word unchanged", v, 32'hA5);
    rd(7, 4, v);  check("R9 first word unchanged", v, 32'h0);
    rd(7, 0, v);  check("R9 ctl unchanged", v, 32'h10);
    rd(8, 4, v);  check("R10 next slot unchanged", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_data();
    t_latency();
    t_mode();
    t_illegal();
    t_auto();
    t_irq();
    t_unimpl();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule